// File: doc/BRIEF.md
# Mode S Address/Parity Field Encoder

This block produces the address/parity field that closes a Mode S interrogation message. The message arrives one bit per beat on a valid/ready stream. The leading data beats are copied to the output stream, and at the same time they are divided into a 24-stage generator register. The closing 24 beats of the message do not carry data. In these beats the register shifts out its remainder with the generator feedback opened. Each remainder bit is XORed with the matching bit of the 24-bit aircraft address, most significant bit first.

A message begins with a beat that has `in_start` set. That beat clears the register and samples three controls: the length select (56 or 112 bits), the aircraft address and the mode. In encode mode the sender still presents a beat for each field position, but the bit value on those beats is not used. In check mode the sender supplies a received field. Each output field bit then becomes the received bit XOR parity XOR address, so a received message with no errors yields 24 zero bits.

Back-pressure rules: an input beat transfers on a clock edge where `in_valid` and `in_ready` are both high. An output beat transfers on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that cycle. While `out_valid` is high and `out_ready` is low, the output beat is held unchanged and `in_ready` stays low.

Top module: `modes_ap_encoder`

## Requirements
- R1: During reset and at the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A data beat accepted while a message is live appears on `out_bit`, unchanged, with `out_valid` set, in the cycle after the accepting edge.
- R3: When `in_long` is 0 on the start beat, the message is 56 beats long: beats 0 to 31 are data and beats 32 to 55 are the field.
- R4: When `in_long` is 1 on the start beat, the message is 112 beats long: beats 0 to 87 are data and beats 88 to 111 are the field.
- R5: In encode mode (`chk_mode` 0), field output bit j (j = 0 first) equals bit 23-j of R XOR A. R is the remainder of the data polynomial times x^24 divided by x^24 + 0xFFF409, with the first data bit as the highest power. A is the address. The remainder starts from zero at every start beat.
- R6: In encode mode, `in_bit` on field beats has no effect on the output.
- R7: `out_last` is 1 on the final output beat of a message (the 56th or the 112th) and 0 on every other beat.
- R8: In check mode (`chk_mode` 1), each field output bit is the incoming bit XOR the parity bit XOR the address bit. A correct field yields 24 zeros, and a field with one inverted bit yields a single 1 at that position.
- R9: A beat accepted without `in_start` while no message is live is dropped and produces no output. A start beat received during a message abandons that message and begins a new one.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_bit` and `out_last` hold their values and `in_ready` is 0. No beat is lost or repeated.
- R11: `in_long`, `in_addr` and `chk_mode` are used only on the start beat. Changing them on later beats has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_mode | input | 1 | 0 = encode, 1 = check; sampled on the start beat |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat may transfer |
| in_bit | input | 1 | Message bit of the beat |
| in_start | input | 1 | Beat is bit 0 of a new message |
| in_long | input | 1 | 1 = 112-bit message, 0 = 56-bit; sampled on the start beat |
| in_addr | input | 24 | Aircraft address; sampled on the start beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat may transfer |
| out_bit | output | 1 | Output message bit |
| out_last | output | 1 | Output beat is the final bit of the message |

## Verification
Each output beat is due one clock edge after its input beat was accepted, because a single register lies on the path. The bench therefore drives inputs just after a rising edge and samples at the falling edge that follows. An output beat is recorded at the falling edge before the rising edge on which it transfers. The field bits and `out_last` follow the same one-edge delay as the data bits, so each captured message is compared position by position against a remainder computed in the bench. Under back-pressure the bench checks the held beat over several stalled cycles, and it checks that nothing leaves the block one cycle after an idle beat is dropped.

// File: rtl/modes_ap_pkg.sv
package modes_ap_pkg;
  localparam int unsigned PAR_W      = 24;
  localparam logic [23:0] GEN_POLY   = 24'hFFF409;
  localparam int unsigned SHORT_BITS = 56;
  localparam int unsigned LONG_BITS  = 112;

  typedef enum logic {
    MODE_ENC = 1'b0,
    MODE_CHK = 1'b1
  } ap_mode_t;
endpackage

// File: rtl/modes_ap_seq.sv
module modes_ap_seq
  import modes_ap_pkg::*;
#(
  parameter int unsigned PW     = PAR_W,
  parameter int unsigned N_SHORT = SHORT_BITS,
  parameter int unsigned N_LONG  = LONG_BITS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic start,
  input  logic long_sel,
  output logic live,
  output logic in_field,
  output logic is_final
);
  localparam int unsigned CW = $clog2(N_LONG + 1);

  logic          active_q;
  logic          long_q;
  logic [CW-1:0] cnt_q;
  logic          cur_long;
  logic [CW-1:0] pos;
  logic [CW-1:0] len;
  logic [CW-1:0] data_len;

  always_comb begin
    cur_long = start ? long_sel : long_q;
    pos      = start ? '0 : cnt_q;
    len      = cur_long ? CW'(N_LONG) : CW'(N_SHORT);
    data_len = len - CW'(PW);
    live     = start || active_q;
    in_field = (pos >= data_len);
    is_final = (pos == len - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      long_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (take && live) begin
      long_q <= cur_long;
      if (is_final) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        active_q <= 1'b1;
        cnt_q    <= pos + CW'(1);
      end
    end
  end

  // R7
  final_ends_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && live && is_final) |=> !active_q);

  // R3
  pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q != '0) && (cnt_q < (long_q ? CW'(N_LONG) : CW'(N_SHORT))));
endmodule

// File: rtl/modes_ap_parity.sv
module modes_ap_parity
  import modes_ap_pkg::*;
#(
  parameter int unsigned    PW  = PAR_W,
  parameter logic [PW-1:0]  GEN = PW'(GEN_POLY)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          start,
  input  logic          field,
  input  logic          fin,
  input  logic          bit_in,
  input  logic [PW-1:0] addr_in,
  output logic          par_bit,
  output logic          addr_bit
);
  logic [PW-1:0] r_q, a_q;
  logic [PW-1:0] r_base, a_base, r_nxt, a_nxt;
  logic          fb;

  always_comb begin
    r_base = start ? '0 : r_q;
    a_base = start ? addr_in : a_q;
    fb     = !field && (r_base[PW-1] ^ bit_in);
    a_nxt  = field ? {a_base[PW-2:0], 1'b0} : a_base;
  end

  genvar i;
  generate
    for (i = 0; i < PW; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign r_nxt[i] = fb & GEN[i];
      end else begin : g_body
        assign r_nxt[i] = r_base[i-1] ^ (fb & GEN[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_q <= '0;
      a_q <= '0;
    end else if (step) begin
      r_q <= r_nxt;
      a_q <= a_nxt;
    end
  end

  assign par_bit  = r_q[PW-1];
  assign addr_bit = a_q[PW-1];

  // R5
  field_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && fin) |=> (r_q == '0) && (a_q == '0));
endmodule

// File: rtl/modes_ap_outreg.sv
module modes_ap_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic d_bit,
  input  logic d_last,
  input  logic out_ready,
  output logic acc_ok,
  output logic out_valid,
  output logic out_bit,
  output logic out_last
);
  logic v_q, b_q, l_q;

  assign acc_ok = !v_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      b_q <= 1'b0;
      l_q <= 1'b0;
    end else if (acc_ok) begin
      v_q <= load;
      if (load) begin
        b_q <= d_bit;
        l_q <= d_last;
      end
    end
  end

  assign out_valid = v_q;
  assign out_bit   = b_q;
  assign out_last  = l_q;

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_bit) && $stable(out_last));
endmodule

// File: rtl/modes_ap_encoder.sv
module modes_ap_encoder
  import modes_ap_pkg::*;
#(
  parameter int unsigned   PW      = PAR_W,
  parameter logic [PW-1:0] GEN     = PW'(GEN_POLY),
  parameter int unsigned   N_SHORT = SHORT_BITS,
  parameter int unsigned   N_LONG  = LONG_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_bit,
  input  logic          in_start,
  input  logic          in_long,
  input  logic [PW-1:0] in_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_bit,
  output logic          out_last
);
  logic     take, load, live, in_field, is_final;
  logic     par_bit, addr_bit, fld_bit, d_bit;
  ap_mode_t mode_q;

  assign take = in_valid && in_ready;
  assign load = take && live;

  modes_ap_seq #(.PW(PW), .N_SHORT(N_SHORT), .N_LONG(N_LONG)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .start    (in_start),
    .long_sel (in_long),
    .live     (live),
    .in_field (in_field),
    .is_final (is_final)
  );

  modes_ap_parity #(.PW(PW), .GEN(GEN)) par_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (load),
    .start    (in_start),
    .field    (in_field),
    .fin      (is_final),
    .bit_in   (in_bit),
    .addr_in  (in_addr),
    .par_bit  (par_bit),
    .addr_bit (addr_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                mode_q <= MODE_ENC;
    else if (load && in_start) mode_q <= ap_mode_t'(chk_mode);
  end

  always_comb begin
    fld_bit = par_bit ^ addr_bit ^ ((mode_q == MODE_CHK) & in_bit);
    d_bit   = in_field ? fld_bit : in_bit;
  end

  modes_ap_outreg out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .d_bit     (d_bit),
    .d_last    (is_final),
    .out_ready (out_ready),
    .acc_ok    (in_ready),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .out_last  (out_last)
  );

  // R2
  beat_emerges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);

  // R9
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !live) |=> !out_valid);
endmodule

// File: tb/modes_ap_encoder_tb_top.sv
`timescale 1ns/1ps
module modes_ap_encoder_tb_top;
  localparam logic [23:0] POLY = 24'hFFF409;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chk_mode = 1'b0, in_valid = 1'b0, in_bit = 1'b0, in_start = 1'b0, in_long = 1'b0;
  logic [23:0] in_addr = '0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_bit, out_last;

  int checks = 0, errors = 0;
  bit bp_on = 1'b0, rdy_hold = 1'b1;
  logic [15:0] rlfsr = 16'hACE1;
  bit cap_bit [0:255];
  bit cap_last [0:255];
  int cap_n = 0;

  // {long, chk, bp, flip, addr[23:0], seed[31:0]}
  localparam int NV = 8;
  localparam logic [59:0] VEC [0:NV-1] = '{
    {4'b0000, 24'hABCDEF, 32'h1234_5678},
    {4'b1000, 24'h3C5A96, 32'hDEAD_BEEF},
    {4'b0010, 24'h000000, 32'h0BAD_F00D},
    {4'b1010, 24'hFFFFFF, 32'h5EED_0001},
    {4'b0100, 24'h4B1D27, 32'hC0FF_EE11},
    {4'b1100, 24'h900A55, 32'h7777_1234},
    {4'b0101, 24'h123456, 32'h2468_ACE0},
    {4'b1111, 24'hFEDCBA, 32'h1357_9BDF}
  };

  always #2.5 clk = ~clk;

  modes_ap_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .chk_mode(chk_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .in_start(in_start), .in_long(in_long), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input logic [111:0] act, input logic [111:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [111:0] gen_msg(input logic [31:0] seed);
    logic [31:0]  s = seed;
    logic [127:0] m = '0;
    for (int k = 0; k < 4; k++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      m = {m[95:0], s};
    end
    return m[111:0];
  endfunction

  function automatic int msg_len(input bit lng);
    return lng ? 112 : 56;
  endfunction

  function automatic logic [23:0] ref_rem(input bit lng, input logic [111:0] m);
    logic [23:0] r = '0;
    int n = msg_len(lng);
    for (int i = 0; i < n - 24; i++) begin
      logic fb = r[23] ^ m[n-1-i];
      r = {r[22:0], 1'b0} ^ (fb ? POLY : 24'h0);
    end
    return r;
  endfunction

  function automatic logic [23:0] sup_field(input bit lng, input bit flip, input logic [23:0] addr, input logic [111:0] m);
    return ref_rem(lng, m) ^ addr ^ (flip ? 24'h040000 : 24'h0);
  endfunction

  function automatic logic [111:0] exp_out(input bit lng, input bit chkm, input bit flip,
                                           input logic [23:0] addr, input logic [111:0] m);
    logic [111:0] e, mask;
    int n = msg_len(lng);
    mask = (112'd1 << n) - 112'd1;
    if (!lng) mask = {56'd0, {56{1'b1}}};
    e = m & mask;
    e[23:0] = chkm ? (flip ? 24'h040000 : 24'h0) : (ref_rem(lng, m) ^ addr);
    return e;
  endfunction

  task automatic run_msg(input bit lng, input bit chkm, input bit flip, input logic [23:0] addr,
                         input logic [111:0] m, input int i0, input int i1);
    int n = msg_len(lng);
    logic [23:0] sf = sup_field(lng, flip, addr, m);
    int i = i0;
    while (i < i1) begin
      in_valid = 1'b1;
      in_start = (i == 0);
      in_long  = (i == 0) ? lng  : ~lng;
      in_addr  = (i == 0) ? addr : ~addr;
      chk_mode = (i == 0) ? chkm : ~chkm;
      if (i >= n - 24) in_bit = chkm ? sf[23-(i-(n-24))] : m[23-(i-(n-24))];
      else             in_bit = m[n-1-i];
      @(negedge clk);
      if (in_ready) i++;
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_start = 1'b0;
  endtask

  task automatic wait_cap(input int n);
    int g = 0;
    while (cap_n < n && g < 5000) begin @(negedge clk); g++; end
    @(posedge clk); #1;
  endtask

  task automatic verify(input int base, input bit lng, input bit chkm, input bit flip,
                        input logic [23:0] addr, input logic [111:0] m, input string tag);
    logic [111:0] g = '0, e;
    int n = msg_len(lng);
    int nl = 0;
    e = exp_out(lng, chkm, flip, addr, m);
    for (int i = 0; i < n; i++) begin
      g[n-1-i] = cap_bit[base+i];
      if (cap_last[base+i]) nl++;
    end
    chk((g >> 24) == (e >> 24), {tag, " R2 R3 R4 data"}, g >> 24, e >> 24);
    chk(g[23:0] == e[23:0], {tag, chkm ? " R8 R11 field" : " R5 R6 R11 field"}, g[23:0], e[23:0]);
    chk(nl == 1 && cap_last[base+n-1], {tag, " R7 last"}, nl, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      rlfsr = {rlfsr[14:0], rlfsr[15] ^ rlfsr[13] ^ rlfsr[12] ^ rlfsr[10]};
      out_ready = bp_on ? rlfsr[0] : rdy_hold;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (out_valid && out_ready && cap_n < 256) begin
        cap_bit[cap_n]  = out_bit;
        cap_last[cap_n] = out_last;
        cap_n++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [111:0] ma, mb;
    int c0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && in_ready, "R1 in reset", {out_valid, in_ready}, 2'b01);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1 after reset", {out_valid, in_ready}, 2'b01);
    @(posedge clk); #1;

    for (int v = 0; v < NV; v++) begin
      logic [59:0] t = VEC[v];
      logic [111:0] m = gen_msg(t[31:0]);
      bp_on = t[57]; rdy_hold = 1'b1; cap_n = 0;
      run_msg(t[59], t[58], t[56], t[55:32], m, 0, msg_len(t[59]));
      wait_cap(msg_len(t[59]));
      bp_on = 1'b0;
      repeat (3) @(posedge clk); #1;
      verify(0, t[59], t[58], t[56], t[55:32], m, $sformatf("vec%0d", v));
    end

    // R2 one-cycle latency
    ma = gen_msg(32'h0F0F_3333); ma[55] = 1'b1;
    cap_n = 0;
    run_msg(1'b0, 1'b0, 1'b0, 24'h55AA55, ma, 0, 1);
    chk(out_valid && out_bit == ma[55], "R2 latency", {out_valid, out_bit}, {1'b1, ma[55]});
    run_msg(1'b0, 1'b0, 1'b0, 24'h55AA55, ma, 1, 56);
    wait_cap(56);
    verify(0, 1'b0, 1'b0, 1'b0, 24'h55AA55, ma, "latency");

    // R9 idle beat dropped
    repeat (2) @(posedge clk); #1;
    c0 = cap_n;
    in_valid = 1'b1; in_start = 1'b0; in_bit = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    chk(!out_valid && cap_n == c0, "R9 idle drop", {out_valid, 8'(cap_n)}, {1'b0, 8'(c0)});
    @(posedge clk); #1;

    // R9 restart mid-message
    ma = gen_msg(32'h9999_AAAA); mb = gen_msg(32'h4242_1717);
    cap_n = 0;
    run_msg(1'b1, 1'b0, 1'b0, 24'h0A0B0C, ma, 0, 5);
    run_msg(1'b0, 1'b0, 1'b0, 24'hC0B0A0, mb, 0, 56);
    wait_cap(61);
    chk(!cap_last[0] && !cap_last[4] && cap_n == 61, "R9 restart count", cap_n, 61);
    verify(5, 1'b0, 1'b0, 1'b0, 24'hC0B0A0, mb, "restart R9");

    // R10 stall hold
    mb = gen_msg(32'h3141_5926); mb[111] = 1'b0;
    rdy_hold = 1'b0;
    @(posedge clk); #1;
    cap_n = 0;
    run_msg(1'b1, 1'b0, 1'b0, 24'h777777, mb, 0, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid && out_bit == mb[111] && !in_ready, "R10 stall hold",
          {out_valid, out_bit, in_ready}, {1'b1, mb[111], 1'b0});
    end
    @(posedge clk); #1;
    rdy_hold = 1'b1;
    @(posedge clk); #1;
    run_msg(1'b1, 1'b0, 1'b0, 24'h777777, mb, 1, 112);
    wait_cap(112);
    verify(0, 1'b1, 1'b0, 1'b0, 24'h777777, mb, "stall R10");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule